// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Look-Ahead Carry

This block is a synchronous counter, six bits wide by default. It can be chained with identical stages to build wider counters. A two-bit mode input selects one of four actions: parallel load, count up, count down or hold. Counting is gated by two active-low enables. The first is a ripple carry input. The second is a look-ahead carry input, which passes through a flip-flop before it takes effect.

The block drives two active-low outputs. The carry output is low while the stage sits at terminal count with its carry input asserted. The look-ahead carry output pulses low for one clock, in the cycle just before the stage reaches terminal count.

To build a chain:
- Tie the least significant stage's carry input and look-ahead input low.
- Connect each stage's carry output to the next stage's carry input.
- Connect the least significant stage's look-ahead output to the look-ahead input of every higher stage.

With this wiring, the ripple path through the carries has a full counter period to settle. The look-ahead path only needs to meet one register setup.

Top module: `cascade_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to zero and sets the look-ahead register to its inactive (high) value. Counting therefore cannot happen on the first edge after reset is released.
- R2: When mode is 2'b00, the next rising edge loads load_val into the count. The carry inputs have no effect on this.
- R3: When mode is 2'b10 and counting is enabled, the count increases by one on each edge. It wraps from all ones to zero.
- R4: When mode is 2'b01 and counting is enabled, the count decreases by one on each edge. It wraps from zero to all ones.
- R5: When mode is 2'b11, the count holds its value.
- R6: While carry_in_n is high, the count does not change in either counting mode.
- R7: lookahead_in_n takes effect one edge late. Counting on an edge requires carry_in_n low in that cycle and lookahead_in_n low in the previous cycle.
- R8: carry_out_n is low exactly when carry_in_n is low and the count equals terminal count. Terminal count is all ones in mode 2'b10 and zero in every other mode.
- R9: lookahead_out_n is low exactly when counting is enabled in a counting mode and the count is one step short of terminal count. That value is all ones minus one when counting up, and one when counting down. The pulse lasts a single clock.
- R10: Two stages chained as described above count up as one 12-bit counter, including across every low-stage wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 load, 01 down, 10 up, 11 hold |
| load_val | input | WIDTH | Parallel load value |
| carry_in_n | input | 1 | Active-low ripple carry enable |
| lookahead_in_n | input | 1 | Active-low look-ahead carry, registered |
| count | output | WIDTH | Current count |
| carry_out_n | output | 1 | Active-low terminal-count carry |
| lookahead_out_n | output | 1 | Active-low carry one clock before terminal count |

## Verification
A wrong count shows on count at the very next edge. A decode error in either carry output shows combinationally in the same cycle. A faulty look-ahead register appears one cycle after the look-ahead input changes: the count steps one edge early or one edge late, or fails to step.

The bench exercises all mode, carry-in and look-ahead combinations across the whole count range, including long random runs. It also runs a two-stage chain through a complete 12-bit period. This catches carry handoffs that go wrong only at a low-stage wrap.

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] load_val,
  input  logic             carry_in_n,
  input  logic             lookahead_in_n,
  output logic [WIDTH-1:0] count,
  output logic             carry_out_n,
  output logic             lookahead_out_n
);
  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_DOWN = 2'b01;
  localparam logic [1:0] M_UP   = 2'b10;
  localparam logic [1:0] M_HOLD = 2'b11;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL = '1;

  logic             la_q;
  logic             is_up, is_down, count_en, step;
  logic [WIDTH-1:0] term, pre_term;

  assign is_up    = (mode == M_UP);
  assign is_down  = (mode == M_DOWN);
  assign count_en = !carry_in_n && !la_q;
  assign step     = (is_up || is_down) && count_en;
  assign term     = is_up ? ALL : '0;
  assign pre_term = is_up ? ALL - ONE : ONE;

  assign carry_out_n     = !(!carry_in_n && count == term);
  assign lookahead_out_n = !(step && count == pre_term);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      la_q  <= 1'b1;
    end else begin
      la_q <= lookahead_in_n;
      case (mode)
        M_LOAD: count <= load_val;
        M_UP:   if (count_en) count <= count + ONE;
        M_DOWN: if (count_en) count <= count - ONE;
        default: ;
      endcase
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (count == '0) && lookahead_out_n);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (mode == M_LOAD) |=> (count == $past(load_val)));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == M_UP && !carry_out_n && !la_q) |=> (count == '0));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DOWN && !carry_out_n && !la_q) |=> (count == ALL));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == M_HOLD) |=> $stable(count));

  a_r6_block: assert property (@(posedge clk) disable iff (rst)
    (carry_in_n && mode != M_LOAD) |=> $stable(count));

  a_r7_registered: assert property (@(posedge clk) disable iff (rst)
    (lookahead_in_n ##1 (mode != M_LOAD)) |=> $stable(count));

  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    !lookahead_out_n |=> lookahead_out_n);
endmodule

// File: tb/cascade_counter_tb.sv
module cascade_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_DOWN = 2'b01;
  localparam logic [1:0] M_UP   = 2'b10;
  localparam logic [1:0] M_HOLD = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = M_HOLD;
  logic [W-1:0] load_val = '0;
  logic cin_n = 1'b1;
  logic lin_n = 1'b1;
  logic [W-1:0] count;
  logic cout_n, lout_n;

  logic [W-1:0] lo_cnt, hi_cnt;
  logic lo_cout, lo_lout, hi_cout, hi_lout;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  logic exp_la = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .load_val(load_val),
    .carry_in_n(cin_n), .lookahead_in_n(lin_n),
    .count(count), .carry_out_n(cout_n), .lookahead_out_n(lout_n));

  cascade_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .rst(rst), .mode(M_UP), .load_val('0),
    .carry_in_n(1'b0), .lookahead_in_n(1'b0),
    .count(lo_cnt), .carry_out_n(lo_cout), .lookahead_out_n(lo_lout));

  cascade_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .rst(rst), .mode(M_UP), .load_val('0),
    .carry_in_n(lo_cout), .lookahead_in_n(lo_lout),
    .count(hi_cnt), .carry_out_n(hi_cout), .lookahead_out_n(hi_lout));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R1 count after reset", int'(count), 0);
    chk("R1 lookahead out after reset", int'(lout_n), 1);
    @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0;
    exp_la = 1'b1;
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] d,
                      input logic ci, input logic li);
    int tc, pre, nxt;
    bit en, counting;
    string tag;
    @(negedge clk);
    mode = m; load_val = d; cin_n = ci; lin_n = li;
    #1;
    tc = (m == M_UP) ? 63 : 0;
    pre = (m == M_UP) ? 62 : 1;
    en = !ci && !exp_la;
    counting = (m == M_UP || m == M_DOWN);
    chk("R8 carry out", int'(cout_n), (!ci && exp_cnt == tc) ? 0 : 1);
    chk("R9 lookahead out", int'(lout_n), (counting && en && exp_cnt == pre) ? 0 : 1);
    nxt = exp_cnt;
    case (m)
      M_LOAD: begin nxt = int'(d); tag = "R2 load"; end
      M_UP: begin
        if (en) nxt = (exp_cnt + 1) % 64;
        tag = en ? "R3 count up" : (ci ? "R6 carry in blocks" : "R7 lookahead registered");
      end
      M_DOWN: begin
        if (en) nxt = (exp_cnt + 63) % 64;
        tag = en ? "R4 count down" : (ci ? "R6 carry in blocks" : "R7 lookahead registered");
      end
      default: tag = "R5 hold";
    endcase
    @(posedge clk);
    exp_cnt = nxt;
    exp_la = li;
    #1;
    chk(tag, int'(count), exp_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    step(M_UP, 6'd0, 1'b0, 1'b0);
    chk("R1 no count on first edge", int'(count), 0);

    // R7: look-ahead asserted alone is one edge too late
    step(M_LOAD, 6'd10, 1'b0, 1'b1);
    step(M_UP, 6'd0, 1'b0, 1'b0);
    chk("R7 no count before lookahead registered", int'(count), 10);
    step(M_UP, 6'd0, 1'b0, 1'b1);
    chk("R7 count after lookahead registered", int'(count), 11);

    step(M_LOAD, 6'd0, 1'b0, 1'b0);
    for (int i = 0; i < 70; i++) step(M_UP, 6'd0, 1'b0, 1'b0);
    step(M_LOAD, 6'd5, 1'b0, 1'b0);
    for (int i = 0; i < 70; i++) step(M_DOWN, 6'd0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(M_HOLD, 6'd0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(M_UP, 6'd0, 1'b1, 1'b0);

    for (int v = 0; v < 64; v++) begin
      for (int c = 0; c < 16; c++) begin
        step(M_LOAD, W'(v), 1'b1, c[3]);
        step(c[1:0], W'(v ^ 6'h2a), c[2], c[3]);
      end
    end

    for (int i = 0; i < 2500; i++) begin
      logic [1:0] m;
      logic ci, li;
      int r;
      r = $urandom;
      m = r[1:0];
      if (r[7:4] != 0 && m == M_LOAD) m = M_UP;
      ci = (r[11:9] == 0);
      li = (r[15:13] == 0);
      step(m, W'(r >> 16), ci, li);
    end

    // R10: two-stage chain over a full 12-bit period
    do_reset();
    for (int k = 1; k <= 4200; k++) begin
      @(posedge clk);
      #1;
      chk("R10 chained count", int'({hi_cnt, lo_cnt}), (k - 1) % 4096);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule